// File: doc/BRIEF.md
# Compare-Driven Output Flag Generator

This block produces the output flag of one timer channel. The counter sits outside it and reports its events as one-cycle strobes: a match against the first compare value, a match against the second, and a rollover. It also reports whether it is counting and the level of its count clock. A 3-bit mode input chooses how these events, plus the rising edge of a secondary input, shape the flag. The modes are: follow the counting state, clear on compare, set on compare, toggle on compare, toggle on alternating compares, set on compare and clear on a secondary edge, set on compare and clear on rollover, and a gated copy of the count clock.

For pulse-width generation the alternating mode is used. While the first compare is armed, the flag is low, so the first compare value sets the low time. Its match raises the flag and arms the second compare, which sets the high time. The block reports which compare is armed so the counter can compare against the right value.

A channel can give control of its flag to a compare broadcast from another counter. In that case the broadcast loads a supplied value into the flag and local compares are ignored. A debug control forces the output low. An inversion control then flips the final output. Because the flag resets low, a channel that never sees a compare gives a 0% duty output, and the same channel with inversion gives a 100% duty output.

Top module: `oflag_gen`

## Requirements
- R1: While reset is asserted, and at the first edge after it, the flag is 0 and the first compare is armed (`use_cmp2` = 0). With `invert` low, `flag_out` is 0.
- R2: In mode 0, `flag_out` follows `cnt_active` in the same cycle. In mode 7 it equals `cnt_active & cnt_clk` in the same cycle. Neither mode changes the stored flag.
- R3: In mode 1 a strobe on `cmp1_hit` or `cmp2_hit` clears the flag. In mode 2 such a strobe sets it. The registered flag shows on `flag_out` after the next clock edge.
- R4: In mode 3 the flag inverts once in any cycle with a strobe on `cmp1_hit` or `cmp2_hit`, including a cycle where both strobe.
- R5: In mode 4 only the strobe of the armed compare counts (`cmp1_hit` when `use_cmp2`=0, `cmp2_hit` when it is 1). Such a strobe inverts the flag and swaps the armed compare. In every other mode the first compare is armed again.
- R6: In mode 5 a compare strobe sets the flag and a rising edge of `sec_in` clears it. When both occur in the same cycle, the set wins.
- R7: In mode 6 a compare strobe sets the flag and `roll_hit` clears it. When both occur in the same cycle, the set wins.
- R8: In modes 1 to 6 with `ext_force_en` high, an `ext_cmp` strobe loads `force_val` into the flag. Local compare, edge and rollover events then have no effect, and the armed compare is held.
- R9: With `dbg_zero` high, the value before inversion is 0, whatever the mode. The stored flag keeps updating.
- R10: `invert` inverts the output last, after the debug force. With no compare events the output stays at its reset level, 0 (or 1 when inverted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Output behaviour select, 0 to 7 |
| cmp1_hit | input | 1 | Strobe: counter matched the first compare value |
| cmp2_hit | input | 1 | Strobe: counter matched the second compare value |
| roll_hit | input | 1 | Strobe: counter rolled over |
| cnt_active | input | 1 | Counter is counting |
| cnt_clk | input | 1 | Level of the count clock |
| sec_in | input | 1 | Secondary input level |
| ext_force_en | input | 1 | Hand flag control to the external broadcast |
| ext_cmp | input | 1 | Strobe: compare broadcast from another counter |
| force_val | input | 1 | Value loaded by the broadcast |
| invert | input | 1 | Invert final output |
| dbg_zero | input | 1 | Debug force of the output to 0 |
| flag_out | output | 1 | Channel output |
| use_cmp2 | output | 1 | Second compare armed (mode 4) |

## Verification
The bench aims at the pulse-width sequence of mode 4, where a strobe from the compare that is not armed must be ignored. A design that toggled on any compare would make the wrong duty cycle, and one that never re-armed after leaving the mode would start the next waveform with the high time. Same-cycle set and clear in modes 5 and 6 are driven on purpose: a design with the wrong priority would leave the flag low. The bench also drives debug together with inversion, where applying the inversion first would give 0 instead of 1. It checks that local compares are ignored under external force, where a design that still obeyed them would move the flag with no broadcast present.

// File: rtl/ofg_pkg.sv
package ofg_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        OM_ACTIVE   = 3'd0,
        OM_CLR      = 3'd1,
        OM_SET      = 3'd2,
        OM_TGL      = 3'd3,
        OM_ALT      = 3'd4,
        OM_SET_SEC  = 3'd5,
        OM_SET_ROLL = 3'd6,
        OM_GATED    = 3'd7
    } omode_e;

    typedef struct packed {
        logic flag;
        logic use_cmp2;
    } core_t;
endpackage

// File: rtl/ofg_edge.sv
module ofg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign rise = sig_in & ~lvl_q;
endmodule

// File: rtl/ofg_flag_core.sv
module ofg_flag_core
    import ofg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cmp1_hit,
    input  logic              cmp2_hit,
    input  logic              roll_hit,
    input  logic              sec_rise,
    input  logic              ext_force_en,
    input  logic              ext_cmp,
    input  logic              force_val,
    output logic              flag_q_o,
    output logic              use_cmp2_o
);
    core_t  st_d, st_q;
    omode_e md;
    logic   any_cmp, armed_hit, stored_mode;

    always_comb begin
        md          = omode_e'(mode);
        any_cmp     = cmp1_hit | cmp2_hit;
        armed_hit   = st_q.use_cmp2 ? cmp2_hit : cmp1_hit;
        stored_mode = (md != OM_ACTIVE) && (md != OM_GATED);
        st_d        = st_q;
        if (md != OM_ALT) st_d.use_cmp2 = 1'b0;
        if (stored_mode && ext_force_en) begin
            if (ext_cmp) st_d.flag = force_val;
        end else begin
            unique case (md)
                OM_CLR:      if (any_cmp) st_d.flag = 1'b0;
                OM_SET:      if (any_cmp) st_d.flag = 1'b1;
                OM_TGL:      if (any_cmp) st_d.flag = ~st_q.flag;
                OM_ALT: begin
                    if (armed_hit) begin
                        st_d.flag     = ~st_q.flag;
                        st_d.use_cmp2 = ~st_q.use_cmp2;
                    end
                end
                OM_SET_SEC: begin
                    if (any_cmp)       st_d.flag = 1'b1;
                    else if (sec_rise) st_d.flag = 1'b0;
                end
                OM_SET_ROLL: begin
                    if (any_cmp)       st_d.flag = 1'b1;
                    else if (roll_hit) st_d.flag = 1'b0;
                end
                OM_ACTIVE, OM_GATED: st_d.flag = st_q.flag;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q_o   = st_q.flag;
    assign use_cmp2_o = st_q.use_cmp2;

    // R3: clear mode never raises the flag locally
    p_clr_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && !ext_force_en) |=> !$rose(st_q.flag));
    // R3: set mode never drops the flag locally
    p_set_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !ext_force_en) |=> !$fell(st_q.flag));
    // R5: armed first compare toggles and arms the second
    p_alt_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && !ext_force_en && !st_q.use_cmp2 && cmp1_hit)
        |=> (st_q.use_cmp2 && st_q.flag != $past(st_q.flag)));
    // R5: outside mode 4 the first compare is armed
    p_alt_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd4) |=> !st_q.use_cmp2);
    // R7: rollover without compare clears
    p_roll_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && !ext_force_en && roll_hit && !cmp1_hit && !cmp2_hit)
        |=> !st_q.flag);
    // R8: broadcast loads the supplied value
    p_ext_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && mode != 3'd7 && ext_force_en && ext_cmp)
        |=> (st_q.flag == $past(force_val)));
    // R8: without broadcast, forced channel holds its flag
    p_ext_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && mode != 3'd7 && ext_force_en && !ext_cmp)
        |=> $stable(st_q.flag));
endmodule

// File: rtl/ofg_out_stage.sv
module ofg_out_stage
    import ofg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_q,
    input  logic              cnt_active,
    input  logic              cnt_clk,
    input  logic              dbg_zero,
    input  logic              invert,
    output logic              flag_out
);
    logic pre;

    always_comb begin
        unique case (omode_e'(mode))
            OM_ACTIVE: pre = cnt_active;
            OM_GATED:  pre = cnt_active & cnt_clk;
            default:   pre = flag_q;
        endcase
        if (dbg_zero) pre = 1'b0;
        flag_out = pre ^ invert;
    end
endmodule

// File: rtl/oflag_gen.sv
module oflag_gen
    import ofg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cmp1_hit,
    input  logic              cmp2_hit,
    input  logic              roll_hit,
    input  logic              cnt_active,
    input  logic              cnt_clk,
    input  logic              sec_in,
    input  logic              ext_force_en,
    input  logic              ext_cmp,
    input  logic              force_val,
    input  logic              invert,
    input  logic              dbg_zero,
    output logic              flag_out,
    output logic              use_cmp2
);
    logic sec_rise, flag_q;

    ofg_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sec_in),
        .rise   (sec_rise)
    );

    ofg_flag_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .cmp1_hit     (cmp1_hit),
        .cmp2_hit     (cmp2_hit),
        .roll_hit     (roll_hit),
        .sec_rise     (sec_rise),
        .ext_force_en (ext_force_en),
        .ext_cmp      (ext_cmp),
        .force_val    (force_val),
        .flag_q_o     (flag_q),
        .use_cmp2_o   (use_cmp2)
    );

    ofg_out_stage u_out (
        .mode       (mode),
        .flag_q     (flag_q),
        .cnt_active (cnt_active),
        .cnt_clk    (cnt_clk),
        .dbg_zero   (dbg_zero),
        .invert     (invert),
        .flag_out   (flag_out)
    );

    // R9/R10: debug force lands before inversion
    p_dbg_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_zero |-> (flag_out == invert));
    // R2: mode 0 follows counting state
    p_active_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !dbg_zero) |-> (flag_out == (cnt_active ^ invert)));
endmodule

// File: tb/tb_oflag_gen.sv
module tb_oflag_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = '0;
    logic c1 = 0, c2 = 0, roll = 0, act = 0, cclk = 0, sec = 0;
    logic exen = 0, extc = 0, fv = 0, inv = 0, dbg = 0;
    logic flag_out, use_cmp2;

    int checks = 0, fails = 0;
    bit done = 0;
    bit m_flag = 0, m_sel = 0, m_sec = 0;

    always #5 clk = ~clk;

    oflag_gen dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmp1_hit(c1), .cmp2_hit(c2),
        .roll_hit(roll), .cnt_active(act), .cnt_clk(cclk), .sec_in(sec),
        .ext_force_en(exen), .ext_cmp(extc), .force_val(fv), .invert(inv),
        .dbg_zero(dbg), .flag_out(flag_out), .use_cmp2(use_cmp2)
    );

    task automatic chk(input logic act_v, input logic exp_v, input string req);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act_v, exp_v, $time);
        end
    endtask

    function automatic logic exp_out();
        logic p;
        case (mode)
            3'd0:    p = act;
            3'd7:    p = act & cclk;
            default: p = m_flag;
        endcase
        if (dbg) p = 1'b0;
        return p ^ inv;
    endfunction

    function automatic string req_tag();
        if (dbg) return "R9";
        if (exen && mode != 3'd0 && mode != 3'd7) return "R8";
        case (mode)
            3'd1, 3'd2: return "R3";
            3'd3:       return "R4";
            3'd4:       return "R5";
            3'd5:       return "R6";
            3'd6:       return "R7";
            default:    return "R2";
        endcase
    endfunction

    task automatic model_step();
        bit any, rise, stored;
        any    = c1 | c2;
        rise   = sec & ~m_sec;
        stored = (mode != 3'd0) && (mode != 3'd7);
        if (mode != 3'd4) m_sel = 0;
        if (stored && exen) begin
            if (extc) m_flag = fv;
        end else begin
            case (mode)
                3'd1: if (any) m_flag = 0;
                3'd2: if (any) m_flag = 1;
                3'd3: if (any) m_flag = ~m_flag;
                3'd4: if (m_sel ? c2 : c1) begin m_flag = ~m_flag; m_sel = ~m_sel; end
                3'd5: if (any) m_flag = 1; else if (rise) m_flag = 0;
                3'd6: if (any) m_flag = 1; else if (roll) m_flag = 0;
                default: ;
            endcase
        end
        m_sec = sec;
    endtask

    // inputs are driven at negedge; model updates at posedge; sample 2 ns later
    task automatic tick(input string req);
        @(posedge clk);
        model_step();
        #2;
        chk(flag_out, exp_out(), req);
        chk(use_cmp2, m_sel, "R5");
        @(negedge clk);
    endtask

    task automatic quiet();
        c1 = 0; c2 = 0; roll = 0; extc = 0; sec = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        chk(flag_out, 1'b0, "R1");
        chk(use_cmp2, 1'b0, "R1");
        rst_n = 1'b1;
        mode = 3'd1;
        tick("R1");
        chk(flag_out, 1'b0, "R1");

        // R5 pulse-width sequence
        mode = 3'd4; quiet();
        c2 = 1; tick("R5");               // unarmed compare ignored
        chk(flag_out, 1'b0, "R5");
        c2 = 0; c1 = 1; tick("R5");       // low time ends
        chk(flag_out, 1'b1, "R5");
        chk(use_cmp2, 1'b1, "R5");
        tick("R5");                       // first compare now unarmed
        chk(flag_out, 1'b1, "R5");
        c1 = 0; c2 = 1; tick("R5");       // high time ends
        chk(flag_out, 1'b0, "R5");
        chk(use_cmp2, 1'b0, "R5");
        c2 = 0; c1 = 1; tick("R5");
        c1 = 0; mode = 3'd3; tick("R5");
        chk(use_cmp2, 1'b0, "R5");

        // R10 0% and 100% duty: no compares
        mode = 3'd1; quiet(); c1 = 1; tick("R10");
        c1 = 0; mode = 3'd4;
        for (int i = 0; i < 6; i++) begin tick("R10"); chk(flag_out, 1'b0, "R10"); end
        inv = 1;
        for (int i = 0; i < 6; i++) begin tick("R10"); chk(flag_out, 1'b1, "R10"); end

        // R9 debug force before inversion
        dbg = 1; mode = 3'd2; c1 = 1; tick("R9");
        chk(flag_out, 1'b1, "R9");
        dbg = 0; c1 = 0; tick("R9");
        chk(flag_out, 1'b0, "R9");        // stored flag set while forced
        inv = 0;

        // R6 same-cycle set and clear
        mode = 3'd1; c1 = 1; tick("R6"); c1 = 0;
        mode = 3'd5; sec = 0; tick("R6");
        sec = 1; c2 = 1; tick("R6");
        chk(flag_out, 1'b1, "R6");
        c2 = 0; sec = 0; tick("R6"); sec = 1; tick("R6");
        chk(flag_out, 1'b0, "R6");
        sec = 0;

        // R7 same-cycle set and rollover
        mode = 3'd6; roll = 1; c1 = 1; tick("R7");
        chk(flag_out, 1'b1, "R7");
        c1 = 0; tick("R7");
        chk(flag_out, 1'b0, "R7");
        roll = 0;

        // R8 local compare ignored under external force
        exen = 1; mode = 3'd2; c1 = 1; tick("R8");
        chk(flag_out, 1'b0, "R8");
        c1 = 0; extc = 1; fv = 1; tick("R8");
        chk(flag_out, 1'b1, "R8");
        extc = 0; exen = 0;

        // R2 same-cycle follow modes
        mode = 3'd7; act = 1; cclk = 1; tick("R2");
        chk(flag_out, 1'b1, "R2");
        mode = 3'd0; act = 0; tick("R2");
        chk(flag_out, 1'b0, "R2");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            if (i % 24 == 0) begin
                mode = 3'($urandom % 8);
                inv  = ($urandom % 3) == 0;
                exen = ($urandom % 5) == 0;
                dbg  = ($urandom % 10) == 0;
            end
            c1   = ($urandom % 4) == 0;
            c2   = ($urandom % 4) == 0;
            roll = ($urandom % 5) == 0;
            act  = 1'($urandom);
            cclk = 1'($urandom);
            sec  = 1'($urandom);
            extc = ($urandom % 4) == 0;
            fv   = 1'($urandom);
            tick(req_tag());
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule